// File: doc/BRIEF.md
# I2C Master Register Front End

This block is the software-facing register file of an I2C master controller. A simple 32-bit word-addressed bus reaches a command register, a 10-bit target address split into two registers, two clock divider registers, transmit and receive FIFO configuration registers, one data window and a status register. The fields it holds are driven straight to a separate bus sequencer. That sequencer generates the bit timing and drives the pins, and it is not part of this block.

A single data offset serves both byte FIFOs, and each FIFO holds 16 entries. A bus write to that offset queues a byte for transmission. A bus read takes the oldest received byte. The sequencer drains the transmit FIFO and fills the receive FIFO through its own strobes. It reports completion, an address not-acknowledge and a data not-acknowledge as one-cycle events. These events are held as sticky status flags, and the enabled flags are combined into a level interrupt.

Software launches a transfer by setting a start bit. That bit stays set until the sequencer accepts the request. The number of bytes to read is written as the count minus one. A FIFO is emptied by writing a one into bit 7 of its configuration register. The status flags are cleared by writing a one into bit 7 of the status register.

Top module: `i2c_reg_front`

## Requirements
- R1: After reset, every register reads 0 and `irq`, `seqStart` and `seqMasterEn` are 0. Both FIFOs are empty: `txEmpty` is 1, and a read of the data offset returns 0.
- R2: Byte offset 0x04 is the command register. Its bits are: 0 master enable, 1 ten-bit address mode, 3 interrupt enable, 4 read direction, 5 combined write-then-read, 6 start. Bit 2 and bits above 6 read 0. Each stored bit appears on its sequencer output in the cycle after the write.
- R3: Byte offset 0x10 holds target address bits 6:0 and byte offset 0x0C holds bits 9:7 in its low 3 bits. `seqTarget` shows the combined 10-bit address.
- R4: Byte offsets 0x14 and 0x18 hold the fast and high speed dividers in their low DIV_W bits. Byte offset 0x20 holds the read length minus one in its low LEN_W bits, which drive `readLenM1`.
- R5: A write of bit 6 of the command register raises `seqStart` after that clock edge. `seqStart` stays high until the edge at which `seqAccept` is sampled high. From that edge on, bit 6 reads 0.
- R6: A write to byte offset 0x24 queues the low byte of the written word in the transmit FIFO. The oldest queued byte appears on `txByte` and `seqTxPop` advances it, in first-in first-out order. A push to a full FIFO is dropped.
- R7: `seqRxPush` stores `rxByte` in the receive FIFO. A read of byte offset 0x24 returns the oldest byte combinationally and removes it at that clock edge. A read while the FIFO is empty returns 0 and changes nothing. A push to a full FIFO is dropped.
- R8: Writing 1 into bit 7 of offset 0x1C empties the transmit FIFO, and writing 1 into bit 7 of offset 0x20 empties the receive FIFO. Both bits read back as 0. Writing 0 into either bit has no effect on the FIFO.
- R9: Status bits 0 (done), 1 (address not acknowledged) and 2 (data not acknowledged) are set by `evtDone`, `evtAddrNack` and `evtDataNack` and stay set. A status write with bit 7 set clears them, and a status write without bit 7 has no effect. An event in the same cycle as a clear leaves its flag set. Bit 7 reads 0.
- R10: `irq` is high exactly when any of status bits 2:0 is set while command bit 3 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe, one access per cycle |
| busWrite | input | 1 | 1 selects write, 0 selects read |
| busAddr | input | 8 | Byte address; bits 7:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the access cycle |
| seqStart | output | 1 | Transfer request held until accepted |
| seqAccept | input | 1 | Sequencer takes the request |
| seqMasterEn | output | 1 | Master enable field |
| seqTenBit | output | 1 | Ten-bit address mode field |
| seqRead | output | 1 | Read direction field |
| seqCombined | output | 1 | Combined write-then-read field |
| seqTarget | output | 10 | Target address |
| fastDiv | output | DIV_W | Fast speed divider |
| highDiv | output | DIV_W | High speed divider |
| readLenM1 | output | LEN_W | Read byte count minus one |
| txByte | output | 8 | Oldest transmit byte, 0 when empty |
| txEmpty | output | 1 | Transmit FIFO empty |
| seqTxPop | input | 1 | Sequencer consumes `txByte` |
| rxByte | input | 8 | Received byte from the sequencer |
| seqRxPush | input | 1 | Store `rxByte` |
| evtDone | input | 1 | Transfer complete event |
| evtAddrNack | input | 1 | Address not acknowledged event |
| evtDataNack | input | 1 | Data not acknowledged event |
| irq | output | 1 | Level interrupt |

## Verification
Register fields, sequencer outputs, FIFO heads and `irq` change at the clock edge that samples the write, push or event, so they are due one edge after the stimulus. The bench applies every stimulus at a falling edge and samples one time unit after the next rising edge. Read data is combinational, so the bench samples it in the access cycle before the edge that performs a receive pop. Command, address, length and status event combinations are swept in loops, and the expected words are computed from the written values by masking and shifting.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;
  localparam logic [5:0] OFS_CMD    = 6'h01;
  localparam logic [5:0] OFS_TGT_HI = 6'h03;
  localparam logic [5:0] OFS_TGT_LO = 6'h04;
  localparam logic [5:0] OFS_DIV_FS = 6'h05;
  localparam logic [5:0] OFS_DIV_HS = 6'h06;
  localparam logic [5:0] OFS_TXCFG  = 6'h07;
  localparam logic [5:0] OFS_RXCFG  = 6'h08;
  localparam logic [5:0] OFS_DATA   = 6'h09;
  localparam logic [5:0] OFS_STAT   = 6'h0A;

  localparam int CMD_MASTER = 0;
  localparam int CMD_TEN    = 1;
  localparam int CMD_IRQEN  = 3;
  localparam int CMD_READ   = 4;
  localparam int CMD_COMB   = 5;
  localparam int CMD_GO     = 6;
  localparam logic [6:0] CMD_KEEP = 7'b1111011;
  localparam int PULSE_BIT  = 7;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic txFlush;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/i2cfe_fifo.sv
module i2cfe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] inData,
  output logic [WIDTH-1:0] headData,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W:0]   FULL_CNT = (PTR_W + 1)'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [PTR_W:0]   count;
  logic             doPush, doPop;

  assign empty    = (count == '0);
  assign doPush   = push && (count != FULL_CNT);
  assign doPop    = pop && !empty;
  assign headData = empty ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R6 R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL_CNT);
  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pop && empty && !push && !flush) |=> empty);
  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);
endmodule

// File: rtl/i2cfe_datapath.sv
module i2cfe_datapath import i2cfe_pkg::*; #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [7:0]   busByte,
  input  logic         seqTxPop,
  input  logic         seqRxPush,
  input  logic [7:0]   rxByte,
  output logic [7:0]   txByte,
  output logic         txEmpty,
  output logic [7:0]   rxHead
);
  logic rxEmpty;
  logic unusedRxEmpty;
  assign unusedRxEmpty = rxEmpty;

  i2cfe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) txFifo_i (
    .clk(clk), .rstN(rstN),
    .push(strobes.txPush), .pop(seqTxPop), .flush(strobes.txFlush),
    .inData(busByte), .headData(txByte), .empty(txEmpty)
  );

  i2cfe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) rxFifo_i (
    .clk(clk), .rstN(rstN),
    .push(seqRxPush), .pop(strobes.rxPop), .flush(strobes.rxFlush),
    .inData(rxByte), .headData(rxHead), .empty(rxEmpty)
  );
endmodule

// File: rtl/i2cfe_ctrl.sv
module i2cfe_ctrl import i2cfe_pkg::*; #(
  parameter int DIV_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic             seqAccept,
  input  logic             evtDone,
  input  logic             evtAddrNack,
  input  logic             evtDataNack,
  input  logic [7:0]       rxHead,
  output fifoStrobes_t     strobes,
  output logic [6:0]       cmdBits,
  output logic [9:0]       target,
  output logic [DIV_W-1:0] fastDiv,
  output logic [DIV_W-1:0] highDiv,
  output logic [LEN_W-1:0] readLenM1,
  output logic             irq
);
  logic [5:0] wordIdx;
  logic       wrEn, rdEn, statClear;
  logic [6:0] cmdReg;
  logic [6:0] tgtLo;
  logic [2:0] tgtHi;
  logic [2:0] statusReg, newEvents;
  logic       unusedBus;

  assign wordIdx   = busAddr[7:2];
  assign wrEn      = busSel && busWrite;
  assign rdEn      = busSel && !busWrite;
  assign statClear = wrEn && (wordIdx == OFS_STAT) && busWdata[PULSE_BIT];
  assign newEvents = {evtDataNack, evtAddrNack, evtDone};
  assign unusedBus = ^{busAddr[1:0], busWdata};

  assign strobes.txPush  = wrEn && (wordIdx == OFS_DATA);
  assign strobes.rxPop   = rdEn && (wordIdx == OFS_DATA);
  assign strobes.txFlush = wrEn && (wordIdx == OFS_TXCFG) && busWdata[PULSE_BIT];
  assign strobes.rxFlush = wrEn && (wordIdx == OFS_RXCFG) && busWdata[PULSE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg    <= '0;
      tgtLo     <= '0;
      tgtHi     <= '0;
      fastDiv   <= '0;
      highDiv   <= '0;
      readLenM1 <= '0;
      statusReg <= '0;
    end else begin
      if (wrEn && wordIdx == OFS_CMD)
        cmdReg <= busWdata[6:0] & CMD_KEEP;
      else if (seqAccept && cmdReg[CMD_GO])
        cmdReg[CMD_GO] <= 1'b0;
      if (wrEn && wordIdx == OFS_TGT_LO) tgtLo     <= busWdata[6:0];
      if (wrEn && wordIdx == OFS_TGT_HI) tgtHi     <= busWdata[2:0];
      if (wrEn && wordIdx == OFS_DIV_FS) fastDiv   <= busWdata[DIV_W-1:0];
      if (wrEn && wordIdx == OFS_DIV_HS) highDiv   <= busWdata[DIV_W-1:0];
      if (wrEn && wordIdx == OFS_RXCFG)  readLenM1 <= busWdata[LEN_W-1:0];
      statusReg <= (statClear ? 3'b000 : statusReg) | newEvents;
    end
  end

  assign cmdBits = cmdReg;
  assign target  = {tgtHi, tgtLo};
  assign irq     = cmdReg[CMD_IRQEN] && (statusReg != 3'b000);

  always_comb begin
    case (wordIdx)
      OFS_CMD:    busRdata = 32'(cmdReg);
      OFS_TGT_HI: busRdata = 32'(tgtHi);
      OFS_TGT_LO: busRdata = 32'(tgtLo);
      OFS_DIV_FS: busRdata = 32'(fastDiv);
      OFS_DIV_HS: busRdata = 32'(highDiv);
      OFS_RXCFG:  busRdata = 32'(readLenM1);
      OFS_DATA:   busRdata = 32'(rxHead);
      OFS_STAT:   busRdata = 32'(statusReg);
      default:    busRdata = 32'h0;
    endcase
  end

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg[CMD_GO] && seqAccept && !(wrEn && wordIdx == OFS_CMD)) |=> !cmdReg[CMD_GO]);
  // R5
  start_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReg[CMD_GO] && !seqAccept && !(wrEn && wordIdx == OFS_CMD)) |=> cmdReg[CMD_GO]);
  // R9
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusReg[1] && !statClear) |=> statusReg[1]);
  // R9
  event_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtDataNack |=> statusReg[2]);
  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(newEvents) != 3'b000 || $past(wrEn && wordIdx == OFS_CMD)));
endmodule

// File: rtl/i2c_reg_front.sv
module i2c_reg_front import i2cfe_pkg::*; #(
  parameter int DIV_W      = 16,
  parameter int FIFO_DEPTH = 16,
  localparam int LEN_W     = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [7:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  output logic             seqStart,
  input  logic             seqAccept,
  output logic             seqMasterEn,
  output logic             seqTenBit,
  output logic             seqRead,
  output logic             seqCombined,
  output logic [9:0]       seqTarget,
  output logic [DIV_W-1:0] fastDiv,
  output logic [DIV_W-1:0] highDiv,
  output logic [LEN_W-1:0] readLenM1,
  output logic [7:0]       txByte,
  output logic             txEmpty,
  input  logic             seqTxPop,
  input  logic [7:0]       rxByte,
  input  logic             seqRxPush,
  input  logic             evtDone,
  input  logic             evtAddrNack,
  input  logic             evtDataNack,
  output logic             irq
);
  fifoStrobes_t strobes;
  logic [6:0]   cmdBits;
  logic [7:0]   rxHead;

  i2cfe_ctrl #(.DIV_W(DIV_W), .LEN_W(LEN_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .seqAccept(seqAccept),
    .evtDone(evtDone), .evtAddrNack(evtAddrNack), .evtDataNack(evtDataNack),
    .rxHead(rxHead), .strobes(strobes), .cmdBits(cmdBits),
    .target(seqTarget), .fastDiv(fastDiv), .highDiv(highDiv),
    .readLenM1(readLenM1), .irq(irq)
  );

  i2cfe_datapath #(.FIFO_DEPTH(FIFO_DEPTH)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busByte(busWdata[7:0]),
    .seqTxPop(seqTxPop), .seqRxPush(seqRxPush), .rxByte(rxByte),
    .txByte(txByte), .txEmpty(txEmpty), .rxHead(rxHead)
  );

  assign seqStart    = cmdBits[CMD_GO];
  assign seqMasterEn = cmdBits[CMD_MASTER];
  assign seqTenBit   = cmdBits[CMD_TEN];
  assign seqRead     = cmdBits[CMD_READ];
  assign seqCombined = cmdBits[CMD_COMB];
endmodule

// File: tb/i2c_reg_front_tb_top.sv
module i2c_reg_front_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busSel = 0, busWrite = 0;
  logic [7:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic seqStart, seqAccept = 0, seqMasterEn, seqTenBit, seqRead, seqCombined;
  logic [9:0] seqTarget;
  logic [15:0] fastDiv, highDiv;
  logic [3:0] readLenM1;
  logic [7:0] txByte, rxByte = 0;
  logic txEmpty, seqTxPop = 0, seqRxPush = 0;
  logic evtDone = 0, evtAddrNack = 0, evtDataNack = 0, irq;

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_reg_front dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .seqStart(seqStart), .seqAccept(seqAccept), .seqMasterEn(seqMasterEn),
    .seqTenBit(seqTenBit), .seqRead(seqRead), .seqCombined(seqCombined),
    .seqTarget(seqTarget), .fastDiv(fastDiv), .highDiv(highDiv),
    .readLenM1(readLenM1), .txByte(txByte), .txEmpty(txEmpty),
    .seqTxPop(seqTxPop), .rxByte(rxByte), .seqRxPush(seqRxPush),
    .evtDone(evtDone), .evtAddrNack(evtAddrNack), .evtDataNack(evtDataNack),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); #1;
    busSel = 0;
  endtask

  task automatic rxPush(input logic [7:0] b);
    @(negedge clk);
    seqRxPush = 1; rxByte = b;
    @(posedge clk); #1;
    seqRxPush = 0;
  endtask

  task automatic txPop();
    @(negedge clk);
    seqTxPop = 1;
    @(posedge clk); #1;
    seqTxPop = 0;
  endtask

  task automatic pulseEvents(input logic [2:0] e);
    @(negedge clk);
    {evtDataNack, evtAddrNack, evtDone} = e;
    @(posedge clk); #1;
    {evtDataNack, evtAddrNack, evtDone} = 3'b000;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 seqStart", 32'(seqStart), 0);
    chk("R1 seqMasterEn", 32'(seqMasterEn), 0);
    chk("R1 txEmpty", 32'(txEmpty), 1);
    for (int w = 1; w <= 10; w++) begin
      busRd(8'(w * 4), rd);
      chk("R1 register reads 0", rd, 0);
    end

    // R2 command sweep, start bit kept clear
    for (int v = 0; v < 256; v++) begin
      logic [31:0] wv;
      wv = 32'(v) & ~32'h40;
      busWr(8'h04, wv | 32'hFFFF_FF00);
      busRd(8'h04, rd);
      chk("R2 command readback", rd, wv & 32'h3B);
      chk("R2 command outputs", {28'd0, seqCombined, seqRead, seqTenBit, seqMasterEn},
          {28'd0, wv[5], wv[4], wv[1], wv[0]});
    end

    // R3 address sweep
    for (int a = 0; a < 1024; a += 13) begin
      busWr(8'h10, 32'(a) | 32'hFFFF_FF80);
      busWr(8'h0C, 32'(a >> 7) | 32'hFFFF_FFF8);
      chk("R3 seqTarget", 32'(seqTarget), 32'(a));
      busRd(8'h10, rd);
      chk("R3 low readback", rd, 32'(a) & 32'h7F);
      busRd(8'h0C, rd);
      chk("R3 high readback", rd, 32'(a >> 7));
    end

    // R4 dividers and read length
    busWr(8'h14, 32'hABCD_1234);
    busWr(8'h18, 32'h5555_9876);
    chk("R4 fastDiv", 32'(fastDiv), 32'h1234);
    chk("R4 highDiv", 32'(highDiv), 32'h9876);
    busRd(8'h14, rd); chk("R4 fast readback", rd, 32'h1234);
    busRd(8'h18, rd); chk("R4 high readback", rd, 32'h9876);
    for (int n = 1; n <= DEPTH; n++) begin
      busWr(8'h20, 32'(n - 1) | 32'hFF00);
      chk("R4 readLenM1", 32'(readLenM1), 32'(n - 1));
      busRd(8'h20, rd);
      chk("R4 length readback", rd, 32'(n - 1));
    end

    // R5 start handshake
    busWr(8'h04, 32'h49);
    chk("R5 start raised", 32'(seqStart), 1);
    repeat (3) @(posedge clk);
    #1 chk("R5 start held", 32'(seqStart), 1);
    @(negedge clk); seqAccept = 1;
    @(posedge clk); #1 seqAccept = 0;
    chk("R5 start cleared", 32'(seqStart), 0);
    busRd(8'h04, rd);
    chk("R5 command after accept", rd, 32'h09);

    // R6 transmit FIFO order and overflow drop
    for (int i = 0; i <= DEPTH; i++) busWr(8'h24, 32'h30 + 32'(i) + 32'h1200);
    for (int i = 0; i < DEPTH; i++) begin
      chk("R6 txByte order", 32'(txByte), 32'h30 + 32'(i));
      chk("R6 txEmpty low", 32'(txEmpty), 0);
      txPop();
    end
    chk("R6 extra push dropped", 32'(txEmpty), 1);

    // R8 transmit flush
    for (int i = 0; i < 3; i++) busWr(8'h24, 32'h70 + 32'(i));
    busWr(8'h1C, 32'h00);
    chk("R8 write of 0 keeps tx", 32'(txByte), 32'h70);
    busWr(8'h1C, 32'h80);
    chk("R8 tx flushed", 32'(txEmpty), 1);
    busRd(8'h1C, rd);
    chk("R8 tx flush bit reads 0", rd, 0);

    // R7 receive FIFO order, drop on full, empty reads
    for (int i = 0; i <= DEPTH; i++) rxPush(8'hA0 + 8'(i));
    for (int i = 0; i < DEPTH; i++) begin
      busRd(8'h24, rd);
      chk("R7 rx order", rd, 32'hA0 + 32'(i));
    end
    busRd(8'h24, rd); chk("R7 empty read 0", rd, 0);
    busRd(8'h24, rd); chk("R7 second empty read 0", rd, 0);
    rxPush(8'h55);
    busRd(8'h24, rd); chk("R7 push after empty reads", rd, 32'h55);

    // R8 receive flush
    rxPush(8'h11); rxPush(8'h22);
    busWr(8'h20, 32'h05);
    busRd(8'h24, rd); chk("R8 write of 0 keeps rx", rd, 32'h11);
    busWr(8'h20, 32'h85);
    busRd(8'h24, rd); chk("R8 rx flushed", rd, 0);
    chk("R8 length kept with flush", 32'(readLenM1), 5);
    busRd(8'h20, rd); chk("R8 rx flush bit reads 0", rd, 5);

    // R9 R10 status and interrupt sweep
    for (int en = 0; en < 2; en++) begin
      for (int e = 0; e < 8; e++) begin
        busWr(8'h04, en ? 32'h08 : 32'h00);
        busWr(8'h28, 32'h80);
        chk("R9 cleared", 32'(irq), 0);
        pulseEvents(3'(e));
        chk("R10 irq level", 32'(irq), 32'((en == 1) && (e != 0)));
        busRd(8'h28, rd);
        chk("R9 flags set", rd, 32'(e));
        busWr(8'h28, 32'h7F);
        busRd(8'h28, rd);
        chk("R9 write without bit 7 ignored", rd, 32'(e));
        busWr(8'h28, 32'h80);
        busRd(8'h28, rd);
        chk("R9 clear", rd, 0);
        chk("R10 irq after clear", 32'(irq), 0);
      end
    end
    // R10 enable applied later
    busWr(8'h04, 32'h00);
    pulseEvents(3'b100);
    chk("R10 masked", 32'(irq), 0);
    busWr(8'h04, 32'h08);
    chk("R10 enabled later", 32'(irq), 1);

    // R9 event in the same cycle as clear
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = 8'h28; busWdata = 32'h80; evtDone = 1;
    @(posedge clk); #1;
    busSel = 0; busWrite = 0; evtDone = 0;
    busRd(8'h28, rd);
    chk("R9 event wins over clear", rd, 32'h1);

    finishRun();
  end
endmodule